// File: doc/BRIEF.md
# Dual-Clock Nibble Gearbox FIFO

This block moves several parallel data lanes from a write clock domain into an independent read clock domain through a shallow eight-word store. It has two static modes, picked by a parameter. In the widening mode, which is the default, each of the ten lanes accepts four bits per write. Two consecutive writes form one byte per lane, and the reader sees one byte-wide word for every two writes. In the pass-through mode, each lane carries four bits straight through. Two extra nibble lanes ride in the upper halves of lanes 5 and 6, which gives twelve nibble lanes in total.

The reader sees the oldest stored word on the output bus as soon as it exists (first-word fall-through) and pops it with a read enable. Each side has a full or empty flag and an early-warning flag in its own clock domain. The early-warning thresholds are parameters that may be 1 or 2. Pointers cross between the domains in Gray code through two-flop synchronizers, so a flag can lag the true fill level by a few cycles of the far clock. It never lags in the unsafe direction.

Top module: `gbx_fifo`

## Requirements
- R1: `rst_in` is active high and asynchronous, and it is released synchronously in each domain. While it is held, and after it is released with no traffic, `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0. A reset in the middle of traffic discards all stored words.
- R2: The store holds 8 words. `full` rises in the write clock cycle after the eighth unread word is completed, and it stays high until reads are seen.
- R3: A write cycle while `full` is high is ignored. The stored words and their order are unchanged, and exactly 8 words can still be read afterwards.
- R4: A read cycle while `empty` is high is ignored. The next word written is the next word read.
- R5: While `empty` is low, `rd_data` shows the oldest unread word. Each cycle with `rd_en` high pops one word, and words leave in the order they were written. Pointers cross the domains in Gray code, changing by at most one bit per cycle.
- R6: Widening mode (`MODE`=MODE_WIDE): per lane n, the nibble in `wr_data[8n+3:8n]` of the first write of a pair goes to `rd_data[8n+3:8n]`, and that of the second write goes to `rd_data[8n+7:8n+4]`. Upper input nibbles are ignored. A lone first nibble leaves `empty` high.
- R7: Pass-through mode (`MODE`=MODE_PASS): each write is one word. `rd_data[8n+3:8n]` carries `wr_data[8n+3:8n]`. Bits [7:4] of lanes 5 and 6 carry the matching input bits. The upper nibbles of all other lanes read as zero, whatever was written there.
- R8: `almost_full` is high while the free space seen by the writer is at most `AF_LEVEL` words (1 or 2).
- R9: `almost_empty` is high while the word count seen by the reader is at most `AE_LEVEL` (1 or 2), and this includes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst_in | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Write strobe, one nibble (wide) or word (pass) per cycle |
| wr_data | input | LANES*8 | Lane inputs, lane n at bits [8n+7:8n] |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | LANES*8 | Head word, lane n at bits [8n+7:8n] |
| full | output | 1 | Store full, write domain |
| almost_full | output | 1 | Free space at or below AF_LEVEL, write domain |
| empty | output | 1 | No word to read, read domain |
| almost_empty | output | 1 | Word count at or below AE_LEVEL, read domain |

## Verification
Each lane and each word uses a different nibble pattern, and the two halves of every byte differ. A swapped nibble order, a lane mix-up or an off-by-one in the pointers therefore gives a wrong byte instead of a match by accident. Widening mode is filled to capacity nibble by nibble, with the flags sampled after each word, so thresholds of 1 and 2 can be told apart from a count that is one word off. Pass-through mode gets distinct values in every upper nibble, which separates the two carried extra lanes from the lanes whose upper bits must read zero. Overflow, underflow and a mid-traffic reset are each followed by a full drain, which shows whether pointers moved when they should not have.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_WIDE = 1'b1
    } gbx_mode_e;

    localparam int NIB_W      = 4;
    localparam int LANE_W     = 2 * NIB_W;
    localparam int EXTRA_LO   = 5;
    localparam int EXTRA_HI   = 6;

    function automatic bit lane_carries_extra(input int lane);
        return (lane == EXTRA_LO) || (lane == EXTRA_HI);
    endfunction

endpackage

// File: rtl/gbx_rst_sync.sv
module gbx_rst_sync (
    input  logic clk,
    input  logic arst,
    output logic rst
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) stage_q <= 2'b11;
        else      stage_q <= {stage_q[0], 1'b0};
    end

    assign rst = stage_q[1];
endmodule

// File: rtl/gbx_ptr_sync.sv
module gbx_ptr_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gbx_wr_side.sv
module gbx_wr_side
    import gbx_pkg::*;
#(
    parameter int        LANES    = 10,
    parameter int        ADDR_W   = 3,
    parameter gbx_mode_e MODE     = MODE_WIDE,
    parameter int        AF_LEVEL = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W:0]          rptr_gray_s,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [LANES*LANE_W-1:0]  mem_wdata,
    output logic [ADDR_W:0]          wptr_gray,
    output logic                     full,
    output logic                     almost_full
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW:0] DEPTH_X = (PW+1)'(1 << ADDR_W);
    localparam logic [PW:0] AF_X    = (PW+1)'(AF_LEVEL);

    logic [ADDR_W:0]        wbin_q;
    logic [ADDR_W:0]        rbin_s;
    logic [ADDR_W:0]        used;
    logic                   half_q;
    logic [LANES*NIB_W-1:0] stage_q;
    logic                   accept;

    for (genvar i = 0; i <= ADDR_W; i++) begin : g_g2b
        assign rbin_s[i] = ^rptr_gray_s[ADDR_W:i];
    end

    assign used        = wbin_q - rbin_s;
    assign full        = used[ADDR_W];
    assign almost_full = ({1'b0, used} + AF_X) >= DEPTH_X;
    assign accept      = wr_en && !full;
    assign mem_we      = accept && ((MODE == MODE_PASS) || half_q);
    assign mem_waddr   = wbin_q[ADDR_W-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (MODE == MODE_WIDE) begin : g_wide
            assign mem_wdata[l*LANE_W +: LANE_W] =
                {wr_data[l*LANE_W +: NIB_W], stage_q[l*NIB_W +: NIB_W]};
        end else if (lane_carries_extra(l)) begin : g_extra
            assign mem_wdata[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
        end else begin : g_plain
            assign mem_wdata[l*LANE_W +: LANE_W] = {{NIB_W{1'b0}}, wr_data[l*LANE_W +: NIB_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q    <= '0;
            wptr_gray <= '0;
            half_q    <= 1'b0;
            stage_q   <= '0;
        end else if (accept) begin
            if (mem_we) begin
                wbin_q    <= wbin_q + 1'b1;
                wptr_gray <= (wbin_q + 1'b1) ^ ((wbin_q + 1'b1) >> 1);
                half_q    <= 1'b0;
            end else begin
                half_q <= 1'b1;
                for (int l = 0; l < LANES; l++)
                    stage_q[l*NIB_W +: NIB_W] <= wr_data[l*LANE_W +: NIB_W];
            end
        end
    end
endmodule

// File: rtl/gbx_rd_side.sv
module gbx_rd_side #(
    parameter int ADDR_W   = 3,
    parameter int AE_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wptr_gray_s,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic              empty,
    output logic              almost_empty
);
    localparam logic [ADDR_W:0] AE_X = (ADDR_W+1)'(AE_LEVEL);

    logic [ADDR_W:0] rbin_q;
    logic [ADDR_W:0] wbin_s;
    logic [ADDR_W:0] count;

    for (genvar i = 0; i <= ADDR_W; i++) begin : g_g2b
        assign wbin_s[i] = ^wptr_gray_s[ADDR_W:i];
    end

    assign count        = wbin_s - rbin_q;
    assign empty        = (count == '0);
    assign almost_empty = (count <= AE_X);
    assign mem_raddr    = rbin_q[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q    <= '0;
            rptr_gray <= '0;
        end else if (rd_en && !empty) begin
            rbin_q    <= rbin_q + 1'b1;
            rptr_gray <= (rbin_q + 1'b1) ^ ((rbin_q + 1'b1) >> 1);
        end
    end
endmodule

// File: rtl/gbx_fifo.sv
module gbx_fifo
    import gbx_pkg::*;
#(
    parameter int        LANES    = 10,
    parameter int        ADDR_W   = 3,
    parameter gbx_mode_e MODE     = MODE_WIDE,
    parameter int        AE_LEVEL = 1,
    parameter int        AF_LEVEL = 1
) (
    input  logic                    wr_clk,
    input  logic                    rd_clk,
    input  logic                    rst_in,
    input  logic                    wr_en,
    input  logic [LANES*8-1:0]      wr_data,
    input  logic                    rd_en,
    output logic [LANES*8-1:0]      rd_data,
    output logic                    full,
    output logic                    almost_full,
    output logic                    empty,
    output logic                    almost_empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WORD  = LANES * LANE_W;

    logic              wrst, rrst;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [WORD-1:0]   mem_wdata;
    logic [ADDR_W:0]   wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
    logic [WORD-1:0]   mem_q [DEPTH];

    gbx_rst_sync u_wrst (.clk(wr_clk), .arst(rst_in), .rst(wrst));
    gbx_rst_sync u_rrst (.clk(rd_clk), .arst(rst_in), .rst(rrst));

    gbx_wr_side #(.LANES(LANES), .ADDR_W(ADDR_W), .MODE(MODE), .AF_LEVEL(AF_LEVEL)) u_wr (
        .clk(wr_clk), .rst(wrst), .wr_en(wr_en), .wr_data(wr_data),
        .rptr_gray_s(rptr_gray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .wptr_gray(wptr_gray), .full(full),
        .almost_full(almost_full)
    );

    gbx_rd_side #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(rd_clk), .rst(rrst), .rd_en(rd_en), .wptr_gray_s(wptr_gray_s),
        .mem_raddr(mem_raddr), .rptr_gray(rptr_gray), .empty(empty),
        .almost_empty(almost_empty)
    );

    gbx_ptr_sync #(.W(ADDR_W+1)) u_w2r (.clk(rd_clk), .rst(rrst), .d(wptr_gray), .q(wptr_gray_s));
    gbx_ptr_sync #(.W(ADDR_W+1)) u_r2w (.clk(wr_clk), .rst(wrst), .d(rptr_gray), .q(rptr_gray_s));

    always_ff @(posedge wr_clk) begin
        if (wrst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            mem_q[mem_waddr] <= mem_wdata;
        end
    end

    assign rd_data = mem_q[mem_raddr];
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
    parameter int ADDR_W = 3,
    parameter int WORD   = 80,
    parameter bit NARROW = 1'b0
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_in,
    input logic            wrst,
    input logic            rrst,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            almost_full,
    input logic            empty,
    input logic            almost_empty,
    input logic [ADDR_W:0] wptr_gray,
    input logic [ADDR_W:0] rptr_gray,
    input logic [WORD-1:0] rd_data
);
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst_in || wrst)
        (full && wr_en) |=> $stable(wptr_gray));

    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (rst_in || rrst)
        (empty && rd_en) |=> $stable(rptr_gray));

    p_wgray_step_r5: assert property (@(posedge wr_clk) disable iff (rst_in || wrst)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    p_rgray_step_r5: assert property (@(posedge rd_clk) disable iff (rst_in || rrst)
        $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

    p_full_warns_r8: assert property (@(posedge wr_clk) disable iff (rst_in || wrst)
        full |-> almost_full);

    p_empty_warns_r9: assert property (@(posedge rd_clk) disable iff (rst_in || rrst)
        empty |-> almost_empty);

    p_upper_zero_r7: assert property (@(posedge rd_clk) disable iff (rst_in || rrst)
        (NARROW && !empty) |-> (rd_data[7:4] == 4'h0));
endmodule

bind gbx_fifo gbx_checker #(
    .ADDR_W(ADDR_W), .WORD(LANES*8), .NARROW(MODE == gbx_pkg::MODE_PASS)
) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_in(rst_in), .wrst(wrst), .rrst(rrst),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .almost_full(almost_full),
    .empty(empty), .almost_empty(almost_empty), .wptr_gray(wptr_gray),
    .rptr_gray(rptr_gray), .rd_data(rd_data)
);

// File: tb/tb_gbx_fifo.sv
module tb_gbx_fifo;
    import gbx_pkg::*;

    localparam int LANES = 10;
    localparam int W     = LANES * 8;

    logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic         w_en = 1'b0, r_en = 1'b0, n_w_en = 1'b0, n_r_en = 1'b0;
    logic [W-1:0] w_data = '0, n_w_data = '0;
    logic [W-1:0] r_data, n_r_data;
    logic full, afull, empty, aempty, n_full, n_afull, n_empty, n_aempty;
    int tests = 0, fails = 0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    gbx_fifo dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_in(rst), .wr_en(w_en), .wr_data(w_data),
        .rd_en(r_en), .rd_data(r_data), .full(full), .almost_full(afull),
        .empty(empty), .almost_empty(aempty)
    );

    gbx_fifo #(.MODE(MODE_PASS), .AE_LEVEL(2), .AF_LEVEL(2)) dut_n (
        .wr_clk(wclk), .rd_clk(rclk), .rst_in(rst), .wr_en(n_w_en), .wr_data(n_w_data),
        .rd_en(n_r_en), .rd_data(n_r_data), .full(n_full), .almost_full(n_afull),
        .empty(n_empty), .almost_empty(n_aempty)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input int k, input int l, input int s);
        return 4'(k * 3 + l * 5 + s * 9 + 1);
    endfunction

    function automatic logic [W-1:0] wide_in(input int k, input int s);
        logic [W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*8 +: 8] = {4'(l + 10), nib(k, l, s)};
        return v;
    endfunction

    function automatic logic [W-1:0] wide_exp(input int k);
        logic [W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*8 +: 8] = {nib(k, l, 1), nib(k, l, 0)};
        return v;
    endfunction

    function automatic logic [W-1:0] pass_in(input int k);
        logic [W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*8 +: 8] = {4'(k + l + 2), nib(k, l, 0)};
        return v;
    endfunction

    function automatic logic [W-1:0] pass_exp(input int k);
        logic [W-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[l*8 +: 8] = {(l == 5 || l == 6) ? 4'(k + l + 2) : 4'h0, nib(k, l, 0)};
        return v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (6) @(negedge rclk);
        rst = 1'b0;
        repeat (4) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic wr_wide(input logic [W-1:0] d);
        @(negedge wclk); w_en = 1'b1; w_data = d;
        @(negedge wclk); w_en = 1'b0;
    endtask

    task automatic wr_pass(input logic [W-1:0] d);
        @(negedge wclk); n_w_en = 1'b1; n_w_data = d;
        @(negedge wclk); n_w_en = 1'b0;
    endtask

    task automatic rd_wide(output logic [W-1:0] d);
        @(negedge rclk); d = r_data; r_en = 1'b1;
        @(negedge rclk); r_en = 1'b0;
    endtask

    task automatic rd_pass(output logic [W-1:0] d);
        @(negedge rclk); d = n_r_data; n_r_en = 1'b1;
        @(negedge rclk); n_r_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 empty", W'(empty), W'(1));
        chk("R1 almost_empty", W'(aempty), W'(1));
        chk("R1 full", W'(full), W'(0));
        chk("R1 almost_full", W'(afull), W'(0));
        chk("R1 pass full/empty", W'({n_full, n_afull, n_empty, n_aempty}), W'(4'b0011));
    endtask

    task automatic t_wide_fill();
        logic [W-1:0] d;
        do_reset();
        wr_wide(wide_in(0, 0));
        settle();
        chk("R6 lone nibble keeps empty", W'(empty), W'(1));
        wr_wide(wide_in(0, 1));
        settle();
        chk("R9 one word empty", W'(empty), W'(0));
        chk("R9 one word almost_empty", W'(aempty), W'(1));
        chk("R5 head word visible", r_data, wide_exp(0));
        for (int k = 1; k < 8; k++) begin
            wr_wide(wide_in(k, 0));
            wr_wide(wide_in(k, 1));
            if (k == 1) begin
                settle();
                chk("R9 two words almost_empty", W'(aempty), W'(0));
            end
            if (k == 6) begin
                chk("R8 seven words almost_full", W'(afull), W'(1));
                chk("R2 seven words not full", W'(full), W'(0));
            end
        end
        chk("R2 eight words full", W'(full), W'(1));
        settle();
        for (int k = 0; k < 8; k++) begin
            rd_wide(d);
            chk("R6 byte assembly order", d, wide_exp(k));
        end
        chk("R5 drained empty", W'(empty), W'(1));
        settle();
        chk("R2 full clears after reads", W'(full), W'(0));
    endtask

    task automatic t_pass_overflow();
        logic [W-1:0] d;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            wr_pass(pass_in(k));
            if (k == 4) chk("R8 five words af=2 low", W'(n_afull), W'(0));
            if (k == 5) chk("R8 six words af=2 high", W'(n_afull), W'(1));
            if (k == 1) begin
                settle();
                chk("R9 two words ae=2 high", W'(n_aempty), W'(1));
            end
            if (k == 2) begin
                settle();
                chk("R9 three words ae=2 low", W'(n_aempty), W'(0));
            end
        end
        chk("R2 pass full", W'(n_full), W'(1));
        wr_pass(pass_in(20));
        wr_pass(pass_in(21));
        settle();
        for (int k = 0; k < 8; k++) begin
            rd_pass(d);
            chk("R7 R3 pass word after overflow", d, pass_exp(k));
        end
        chk("R3 nothing extra stored", W'(n_empty), W'(1));
    endtask

    task automatic t_underflow();
        logic [W-1:0] d;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge rclk); r_en = 1'b1;
            @(negedge rclk); r_en = 1'b0;
        end
        chk("R4 still empty", W'(empty), W'(1));
        wr_wide(wide_in(9, 0));
        wr_wide(wide_in(9, 1));
        settle();
        rd_wide(d);
        chk("R4 next word after empty reads", d, wide_exp(9));
        chk("R4 empty after single pop", W'(empty), W'(1));
    endtask

    task automatic t_mid_reset();
        for (int k = 0; k < 3; k++) begin
            wr_wide(wide_in(k, 0));
            wr_wide(wide_in(k, 1));
        end
        settle();
        chk("R1 words present before reset", W'(empty), W'(0));
        do_reset();
        settle();
        chk("R1 reset discards words", W'({empty, aempty, full, afull}), W'(4'b1100));
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_wide_fill();
        t_pass_overflow();
        t_underflow();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule